// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is an 8-bit down-counting timer. It has three byte-wide registers: a count register, a reload register and a control register. A host loads a reload value while the timer is idle. The host then sets the run bit to start the timer.

The block has no free-running clock of its own. A cycle-advance input reports how many core cycles have elapsed since the last report. A prescaler turns those cycles into count decrements. Its ratio is a power of four, chosen in the control register.

Two modes are available. In one-shot mode the timer halts at terminal count. In continuous mode it wraps around through the reload value. Every update, including a multi-tick advance, completes in a single clock. Register reads are combinational.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the count reads 0x00, the reload register reads 0xFF and the control register reads 0x00. The prescaler remainder starts at -1.
- R2: While the timer is stopped, a write to the reload register (address 1) stores the value, loads it into the count, clears the remainder and sets an internal loaded flag. A written value of 0 stands for 256, so both the count and the reload register then read 0x00.
- R3: While the timer runs, reload writes are ignored. Writes to the count register (address 0) are ignored at all times. Reads of address 3 return 0x00.
- R4: While the timer runs, a control write (address 2) changes only bit 1, the run bit. Writing that bit as 0 stops the timer and clears the loaded flag.
- R5: On a start (a control write with bit 1 set while stopped), the divisor is 4^(1+ctrl[5:3]) when ctrl[7:6] is 01. For any other value of ctrl[7:6], the divisor is 4.
- R6: On a start while the loaded flag is clear, the count becomes (count-1) mod 256. The remainder is set to -1 on every start.
- R7: A start in one-shot mode (ctrl bit 0 = 0) that leaves a count of zero clears the run bit at once.
- R8: An advance of N cycles while running adds N to the remainder. Once the remainder reaches the divisor, the count drops by remainder/divisor and the remainder keeps remainder mod divisor. Advances while stopped have no effect.
- R9: In continuous mode (ctrl bit 0 = 1), a count that drops below zero is raised by (reload+1) until it is no longer negative.
- R10: In one-shot mode, the timer forces the count to 0 and stops, clearing the loaded flag, in either of two cases: the count goes negative, or the count is 0 with a remainder of 4 or more.
- R11: A register write and an advance in the same cycle: the write takes effect and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count, 1 reload, 2 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map; 3 reads zero |
| rd_data | output | 8 | Combinational read data |
| adv_en | input | 1 | Cycle-advance strobe |
| adv_cycles | input | ADV_W | Number of elapsed core cycles |

## Verification
Each write or advance is sampled on one rising edge. Its result is visible on the read port directly after that edge, because reads are combinational. The bench drives every operation on a falling edge and releases it at the next falling edge. It then sweeps rd_addr through the three registers within that low phase and compares each value with a bench model stepped once per operation. A one-shot start that stops itself therefore shows a cleared run bit at the very first read after the control write.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int ADV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             adv_en,
  input  logic [ADV_W-1:0] adv_cycles
);
  localparam int SHIFT_W = 5;
  localparam int REM_W   = 16 + ADV_W + 2;

  logic [7:0]               ctrl_q;
  logic                     latched_q;
  logic [8:0]               cnt_q;
  logic [8:0]               latch_q;
  logic [SHIFT_W-1:0]       shift_q;
  logic signed [REM_W-1:0]  rem_q;

  wire running = ctrl_q[1];

  logic signed [REM_W-1:0] rem_sum, div, ticks, rem_next, cnt_dec;
  logic [REM_W-1:0] mag, modv, rmod, wrapped;
  logic oneshot_end;

  assign rem_sum  = rem_q + $signed({{(REM_W-ADV_W){1'b0}}, adv_cycles});
  assign div      = $signed({{(REM_W-1){1'b0}}, 1'b1} << shift_q);
  assign ticks    = (rem_sum >= div) ? (rem_sum >>> shift_q) : '0;
  assign rem_next = (rem_sum >= div) ? (rem_sum & (div - 1)) : rem_sum;
  assign cnt_dec  = $signed({{(REM_W-9){1'b0}}, cnt_q}) - ticks;
  assign mag      = REM_W'(-cnt_dec);
  assign modv     = REM_W'(latch_q) + REM_W'(1);
  assign rmod     = mag % modv;
  assign wrapped  = (rmod == '0) ? '0 : modv - rmod;
  assign oneshot_end = (cnt_dec < 0) || (cnt_dec == 0 && rem_next >= 4);

  logic [8:0]         start_cnt;
  logic [SHIFT_W-1:0] start_shift;
  logic [8:0]         load_val;

  assign start_cnt   = latched_q ? cnt_q : {1'b0, cnt_q[7:0] - 8'd1};
  assign start_shift = (wr_data[7:6] == 2'b01)
                     ? SHIFT_W'({wr_data[5:3], 1'b0}) + SHIFT_W'(2)
                     : SHIFT_W'(2);
  assign load_val    = (wr_data == 8'd0) ? 9'd256 : {1'b0, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      latched_q <= 1'b0;
      cnt_q     <= '0;
      latch_q   <= 9'd255;
      shift_q   <= '0;
      rem_q     <= -1;
    end else if (wr_en) begin
      case (wr_addr)
        2'd1: if (!running) begin
          latch_q   <= load_val;
          cnt_q     <= load_val;
          rem_q     <= '0;
          latched_q <= 1'b1;
        end
        2'd2: if (running) begin
          if (!wr_data[1]) begin
            ctrl_q[1] <= 1'b0;
            latched_q <= 1'b0;
          end
        end else begin
          ctrl_q <= wr_data;
          if (wr_data[1]) begin
            shift_q <= start_shift;
            rem_q   <= -1;
            cnt_q   <= start_cnt;
            if (!wr_data[0] && start_cnt == 9'd0) ctrl_q[1] <= 1'b0;
          end
        end
        default: ;
      endcase
    end else if (adv_en && running) begin
      rem_q <= rem_next;
      if (ctrl_q[0]) begin
        cnt_q <= (cnt_dec < 0) ? 9'(wrapped) : 9'(cnt_dec);
      end else if (oneshot_end) begin
        cnt_q     <= '0;
        ctrl_q[1] <= 1'b0;
        latched_q <= 1'b0;
      end else begin
        cnt_q <= 9'(cnt_dec);
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cnt_q[7:0];
      2'd1:    rd_data = latch_q[7:0];
      2'd2:    rd_data = ctrl_q;
      default: rd_data = 8'd0;
    endcase
  end
endmodule

// File: rtl/prescaled_timer_checks.sv
module prescaled_timer_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       adv_en,
  input logic [7:0] ctrl_q,
  input logic       latched_q,
  input logic [8:0] cnt_q,
  input logic [8:0] latch_q
);
  p_reload_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !ctrl_q[1])
    |=> (latched_q && cnt_q == (($past(wr_data) == 8'd0) ? 9'd256 : {1'b0, $past(wr_data)})));

  p_reload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && ctrl_q[1]) |=> $stable(latch_q));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && ctrl_q[1])
    |=> (ctrl_q[7:2] == $past(ctrl_q[7:2]) && ctrl_q[0] == $past(ctrl_q[0])));

  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && ctrl_q[1] && !wr_data[1])
    |=> (!ctrl_q[1] && !latched_q));

  p_idle_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !wr_en && !ctrl_q[1]) |=> $stable(cnt_q));

  p_oneshot_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[1]) && !$past(wr_en)) |-> (cnt_q == 9'd0 && !latched_q));

  p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 9'd256);
endmodule

bind prescaled_timer prescaled_timer_checks u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .adv_en(adv_en), .ctrl_q(ctrl_q), .latched_q(latched_q), .cnt_q(cnt_q), .latch_q(latch_q)
);

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic adv_en = 1'b0;
  logic [7:0] adv_cycles = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_cnt, m_ctrl, m_latched, m_div, m_rem, m_latch;

  always #10 clk = ~clk;

  prescaled_timer #(.ADV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .adv_en(adv_en), .adv_cycles(adv_cycles)
  );

  function automatic int div_of(int c);
    if (((c >> 6) & 3) == 1) return 1 << (2 * (1 + ((c >> 3) & 7)));
    return 4;
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_ctrl = 0; m_latched = 0; m_div = 1; m_rem = -1; m_latch = 255;
  endtask

  task automatic m_write(int a, int v);
    if (a == 1) begin
      if (!m_ctrl[1]) begin
        m_latch = (v == 0) ? 256 : v;
        m_cnt = m_latch; m_rem = 0; m_latched = 1;
      end
    end else if (a == 2) begin
      if (m_ctrl[1]) begin
        if (!v[1]) begin m_ctrl = m_ctrl & ~2; m_latched = 0; end
      end else begin
        m_ctrl = v;
        if (v[1]) begin
          m_div = div_of(v);
          if (!m_latched) m_cnt = (m_cnt - 1) & 255;
          m_rem = -1;
          if (!v[0] && m_cnt == 0) m_ctrl = m_ctrl & ~2;
        end
      end
    end
  endtask

  task automatic m_adv(int n);
    if (!m_ctrl[1]) return;
    m_rem += n;
    if (m_rem >= m_div) begin
      m_cnt -= m_rem / m_div;
      m_rem = m_rem % m_div;
    end
    if (m_ctrl[0]) begin
      while (m_cnt < 0) m_cnt += m_latch + 1;
    end else if (m_cnt < 0 || (m_cnt == 0 && m_rem >= 4)) begin
      m_cnt = 0; m_ctrl = m_ctrl & ~2; m_latched = 0;
    end
  endtask

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_regs(string req);
    rd_addr = 2'd0; #1 chk(req, "count", rd_data, m_cnt & 255);
    rd_addr = 2'd1; #1 chk(req, "reload", rd_data, m_latch & 255);
    rd_addr = 2'd2; #1 chk(req, "control", rd_data, m_ctrl & 255);
  endtask

  task automatic op(string req, bit we, int a, int v, bit adv, int n);
    @(negedge clk);
    wr_en = we; wr_addr = 2'(a); wr_data = 8'(v);
    adv_en = adv; adv_cycles = 8'(n);
    @(negedge clk);
    wr_en = 1'b0; adv_en = 1'b0;
    if (we) m_write(a, v);
    else if (adv) m_adv(n);
    check_regs(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (2) @(negedge clk);
    check_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    // R2: reload of zero means 256
    op("R2", 1, 1, 0, 0, 0);
    // R5: mode field 00 gives divisor 4; remainder starts at -1
    op("R5", 1, 2, 8'h02, 0, 0);
    op("R8", 0, 0, 0, 1, 4);
    op("R8", 0, 0, 0, 1, 1);
    // R3: reload and count writes ignored while running
    op("R3", 1, 1, 8'h33, 0, 0);
    op("R3", 1, 0, 8'h77, 0, 0);
    // R4: only the run bit changes while running
    op("R4", 1, 2, 8'hFF, 0, 0);
    // R11: write plus advance, advance discarded
    op("R11", 1, 2, 8'h02, 1, 200);
    op("R4", 1, 2, 8'h00, 0, 0);
    // R8: stopped advance has no effect
    op("R8", 0, 0, 0, 1, 100);
    // R6: start without reload pre-decrements
    op("R6", 1, 2, 8'h03, 0, 0);
    op("R4", 1, 2, 8'h01, 0, 0);
    // R9: continuous wrap with large advance, prescaler 4^(1+0)
    op("R2", 1, 1, 3, 0, 0);
    op("R9", 1, 2, 8'h43, 0, 0);
    op("R9", 0, 0, 0, 1, 255);
    op("R9", 0, 0, 0, 1, 7);
    op("R4", 1, 2, 8'h00, 0, 0);
    // R5: mode field 01 with select 1 gives divisor 16
    op("R2", 1, 1, 10, 0, 0);
    op("R5", 1, 2, 8'h4A, 0, 0);
    op("R5", 0, 0, 0, 1, 16);
    op("R5", 0, 0, 0, 1, 15);
    op("R4", 1, 2, 8'h00, 0, 0);
    // R10: one-shot terminal count
    op("R2", 1, 1, 1, 0, 0);
    op("R10", 1, 2, 8'h02, 0, 0);
    op("R10", 0, 0, 0, 1, 8);
    op("R10", 0, 0, 0, 1, 1);
    // R10: count 0 with remainder >= 4 under divisor 16
    op("R2", 1, 1, 1, 0, 0);
    op("R10", 1, 2, 8'h4A, 0, 0);
    op("R10", 0, 0, 0, 1, 17);
    op("R10", 0, 0, 0, 1, 4);
    // R7: one-shot start that leaves zero clears run bit at once
    op("R2", 1, 1, 2, 0, 0);
    op("R7", 1, 2, 8'h02, 0, 0);
    op("R7", 0, 0, 0, 1, 5);
    op("R7", 1, 2, 8'h00, 0, 0);
    op("R7", 1, 2, 8'h02, 0, 0);
    // R3: address 3 reads zero
    rd_addr = 2'd3; #1 chk("R3", "addr3", rd_data, 0);

    // random mix, R8 R9 R10 covered by the model
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      int v = $urandom % 256;
      if (r < 12) op("R2", 1, 1, v, 0, 0);
      else if (r < 24) begin
        if ($urandom % 2) v = (v & 8'h3F) | 8'h40;
        if ($urandom % 4 != 0) v = v & 8'hE7;
        op("R4", 1, 2, v, 0, 0);
      end
      else if (r < 28) op("R3", 1, 0, v, 0, 0);
      else if (r < 31) op("R11", 1, 1 + ($urandom % 2), v, 1, $urandom % 256);
      else op("R8", 0, 0, 0, 1, ($urandom % 3 == 0) ? ($urandom % 256) : ($urandom % 9));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule